// File: doc/BRIEF.md
# JTAG Test Access Port Controller with Configuration Instructions

This block is a complete IEEE 1149.1 test access port controller for the TCK clock domain. It runs the sixteen-state TAP state machine from TMS, with an optional active-low asynchronous test reset. It holds a five-bit instruction register and contains the bypass, identification-code and user-code data registers. The instruction decode covers the standard boundary-scan instructions and several additions: two user-defined scan chains, a configuration-load chain, a configuration-readback chain and a startup-launch instruction.

The scan cells and the configuration memory are not part of this block. They connect through one select output per instruction and through shared capture, shift and update strobes. A test-logic-reset indication and a copy of TDI are also provided, along with one serial-return input per external chain. TDO is registered on the falling edge of TCK and comes with an output-enable that is high only while data or instructions are being shifted.

A typical configuration session over the port has four steps. Load the configuration-load instruction. Stream the bitstream through Shift-DR, then return to Run-Test-Idle. Load the launch instruction and pass once through Shift-DR. Finally, idle in Run-Test-Idle while the startup logic runs from the launch strobe.

Top module: `scan_port_ctrl`

## Requirements
- R1: While trst_n is low, and for two rising TCK edges after it rises, the controller stays in Test-Logic-Reset (tlr_reset=1). The instruction then reads IDCODE, so the first data scan returns the identification word.
- R2: Five consecutive rising TCK edges with TMS=1 reach Test-Logic-Reset (tlr_reset=1) from any state, and the instruction register returns to IDCODE.
- R3: Capture-IR loads the pattern 00001 into the instruction shift stage. The stage shifts toward bit 0, so the first five TDO bits of every IR scan are 1,0,0,0,0.
- R4: The IDCODE instruction (01001) selects a 32-bit word: version in bits 31:28, family in bits 27:21, array size in bits 20:12, manufacturer in bits 11:1, and bit 0 = 1. The word is shifted out least significant bit first.
- R5: BYPASS (11111) and every opcode not listed in R4 to R11 select a one-bit bypass register that captures 0. A scan of n bits returns 0 followed by TDI delayed by one bit.
- R6: The USERCODE instruction (01000) shifts out the 32-bit USER_WORD parameter, least significant bit first.
- R7: User chain A (00010) and user chain B (00011) each raise only their own select and route TDO from their own return input. At most one instruction select is high at any time.
- R8: Configuration load (00101) and configuration readback (00100) each raise their own select, and TDO comes from cfg_tdo.
- R9: HIGHZ (01010) raises outputs_hiz and uses the bypass register. outputs_hiz falls once another instruction is loaded.
- R10: EXTEST (00000), SAMPLE/PRELOAD (00001) and INTEST (00111) raise sel_extest, sel_sample and sel_intest respectively, and route TDO from bsr_tdo.
- R11: The launch instruction (01100) raises sel_launch and uses the bypass register. start_run is high in every Run-Test-Idle cycle while it is current, and low elsewhere.
- R12: dr_capture, dr_shift and dr_update are high exactly in Capture-DR, Shift-DR and Update-DR. tlr_reset is high exactly in Test-Logic-Reset.
- R13: TDO and tdo_oe change only on the falling edge of TCK. tdo_oe is high exactly in the half cycles that follow entry into Shift-IR or Shift-DR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low test reset (tie high if unused) |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial test data in |
| bsr_tdo | input | 1 | Serial return of the boundary-scan chain |
| chain_a_tdo | input | 1 | Serial return of user chain A |
| chain_b_tdo | input | 1 | Serial return of user chain B |
| cfg_tdo | input | 1 | Serial return of the configuration chain |
| tdo | output | 1 | Serial test data out, falling-edge registered |
| tdo_oe | output | 1 | TDO drive enable |
| chain_tdi | output | 1 | TDI forwarded to external chains |
| tlr_reset | output | 1 | High in Test-Logic-Reset |
| dr_capture | output | 1 | High in Capture-DR |
| dr_shift | output | 1 | High in Shift-DR |
| dr_update | output | 1 | High in Update-DR |
| sel_extest | output | 1 | EXTEST is current |
| sel_sample | output | 1 | SAMPLE/PRELOAD is current |
| sel_intest | output | 1 | INTEST is current |
| sel_chain_a | output | 1 | User chain A is current |
| sel_chain_b | output | 1 | User chain B is current |
| sel_cfg_load | output | 1 | Configuration load is current |
| sel_cfg_read | output | 1 | Configuration readback is current |
| sel_launch | output | 1 | Startup launch is current |
| outputs_hiz | output | 1 | HIGHZ is current: device outputs to float |
| start_run | output | 1 | Launch active and controller in Run-Test-Idle |

## Verification
Data scans are run with all-zero TDI against the two 32-bit words. This separates the identification word from the user word, and both from the bypass path, which returns a single 0. Bypass, reserved-opcode and HIGHZ scans use irregular TDI patterns, so a one-bit delay is distinguished from a pass-through or a stuck output. For the external-chain instructions, only the selected return input is driven high and the others are held low, so a mis-routed TDO multiplexer produces zeros. The five-high TMS escape is tried from Pause-IR with the launch instruction loaded and from the middle of a Shift-DR. A scan step is also observed on each side of the rising edge to show that TDO moves only on the falling edge.

// File: rtl/scan_pkg.sv
package scan_pkg;

  localparam int IR_W  = 5;
  localparam int VER_W = 4;
  localparam int FAM_W = 7;
  localparam int SIZ_W = 9;
  localparam int MFR_W = 11;
  localparam int DR_W  = VER_W + FAM_W + SIZ_W + MFR_W + 1;

  typedef enum logic [3:0] {
    ST_RESET, ST_IDLE,
    ST_DR_SEL, ST_DR_CAP, ST_DR_SHIFT, ST_DR_EXIT1, ST_DR_PAUSE, ST_DR_EXIT2, ST_DR_UPD,
    ST_IR_SEL, ST_IR_CAP, ST_IR_SHIFT, ST_IR_EXIT1, ST_IR_PAUSE, ST_IR_EXIT2, ST_IR_UPD
  } tap_state_e;

  typedef logic [IR_W-1:0] opcode_t;

  localparam opcode_t OP_EXTEST   = 5'b00000;
  localparam opcode_t OP_SAMPLE   = 5'b00001;
  localparam opcode_t OP_CHAIN_A  = 5'b00010;
  localparam opcode_t OP_CHAIN_B  = 5'b00011;
  localparam opcode_t OP_CFG_READ = 5'b00100;
  localparam opcode_t OP_CFG_LOAD = 5'b00101;
  localparam opcode_t OP_INTEST   = 5'b00111;
  localparam opcode_t OP_USERCODE = 5'b01000;
  localparam opcode_t OP_IDCODE   = 5'b01001;
  localparam opcode_t OP_HIGHZ    = 5'b01010;
  localparam opcode_t OP_LAUNCH   = 5'b01100;
  localparam opcode_t OP_BYPASS   = 5'b11111;

  // Pattern captured into the instruction shift stage
  localparam opcode_t IR_CAPTURE  = 5'b00001;

  typedef enum logic [2:0] {
    SRC_BYPASS, SRC_WORD, SRC_BOUNDARY, SRC_CHAIN_A, SRC_CHAIN_B, SRC_CFG
  } dr_src_e;

  typedef struct packed {
    dr_src_e src;
    logic    word_user;
    logic    extest;
    logic    sample;
    logic    intest;
    logic    chain_a;
    logic    chain_b;
    logic    cfg_load;
    logic    cfg_read;
    logic    launch;
    logic    hiz;
  } decode_t;

  function automatic decode_t decode_op(input opcode_t op);
    decode_t d;
    d = '0;
    d.src = SRC_BYPASS;
    case (op)
      OP_EXTEST:   begin d.src = SRC_BOUNDARY; d.extest   = 1'b1; end
      OP_SAMPLE:   begin d.src = SRC_BOUNDARY; d.sample   = 1'b1; end
      OP_INTEST:   begin d.src = SRC_BOUNDARY; d.intest   = 1'b1; end
      OP_CHAIN_A:  begin d.src = SRC_CHAIN_A;  d.chain_a  = 1'b1; end
      OP_CHAIN_B:  begin d.src = SRC_CHAIN_B;  d.chain_b  = 1'b1; end
      OP_CFG_LOAD: begin d.src = SRC_CFG;      d.cfg_load = 1'b1; end
      OP_CFG_READ: begin d.src = SRC_CFG;      d.cfg_read = 1'b1; end
      OP_IDCODE:   begin d.src = SRC_WORD; end
      OP_USERCODE: begin d.src = SRC_WORD;     d.word_user = 1'b1; end
      OP_HIGHZ:    begin d.hiz    = 1'b1; end
      OP_LAUNCH:   begin d.launch = 1'b1; end
      default:     begin d.src = SRC_BYPASS; end
    endcase
    return d;
  endfunction

endpackage

// File: rtl/scan_tap_fsm.sv
module scan_tap_fsm
  import scan_pkg::*;
(
  input  logic       tck,
  input  logic       rst_n,
  input  logic       tms,
  output tap_state_e state
);

  tap_state_e state_q;
  tap_state_e state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_RESET:    state_d = tms ? ST_RESET    : ST_IDLE;
      ST_IDLE:     state_d = tms ? ST_DR_SEL   : ST_IDLE;
      ST_DR_SEL:   state_d = tms ? ST_IR_SEL   : ST_DR_CAP;
      ST_DR_CAP:   state_d = tms ? ST_DR_EXIT1 : ST_DR_SHIFT;
      ST_DR_SHIFT: state_d = tms ? ST_DR_EXIT1 : ST_DR_SHIFT;
      ST_DR_EXIT1: state_d = tms ? ST_DR_UPD   : ST_DR_PAUSE;
      ST_DR_PAUSE: state_d = tms ? ST_DR_EXIT2 : ST_DR_PAUSE;
      ST_DR_EXIT2: state_d = tms ? ST_DR_UPD   : ST_DR_SHIFT;
      ST_DR_UPD:   state_d = tms ? ST_DR_SEL   : ST_IDLE;
      ST_IR_SEL:   state_d = tms ? ST_RESET    : ST_IR_CAP;
      ST_IR_CAP:   state_d = tms ? ST_IR_EXIT1 : ST_IR_SHIFT;
      ST_IR_SHIFT: state_d = tms ? ST_IR_EXIT1 : ST_IR_SHIFT;
      ST_IR_EXIT1: state_d = tms ? ST_IR_UPD   : ST_IR_PAUSE;
      ST_IR_PAUSE: state_d = tms ? ST_IR_EXIT2 : ST_IR_PAUSE;
      ST_IR_EXIT2: state_d = tms ? ST_IR_UPD   : ST_IR_SHIFT;
      ST_IR_UPD:   state_d = tms ? ST_DR_SEL   : ST_IDLE;
      default:     state_d = ST_RESET;
    endcase
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) state_q <= ST_RESET;
    else        state_q <= state_d;
  end

  assign state = state_q;

endmodule

// File: rtl/scan_ir.sv
module scan_ir
  import scan_pkg::*;
(
  input  logic       tck,
  input  logic       rst_n,
  input  logic       tdi,
  input  tap_state_e state,
  output opcode_t    ir,
  output logic       sr_lsb
);

  opcode_t sr_q;
  opcode_t sr_d;
  logic    sr_en;
  opcode_t ir_q;
  opcode_t ir_d;
  logic    ir_en;

  always_comb begin
    sr_en = 1'b0;
    sr_d  = sr_q;
    if (state == ST_IR_CAP) begin
      sr_en = 1'b1;
      sr_d  = IR_CAPTURE;
    end else if (state == ST_IR_SHIFT) begin
      sr_en = 1'b1;
      sr_d  = {tdi, sr_q[IR_W-1:1]};
    end
  end

  always_comb begin
    ir_en = 1'b0;
    ir_d  = ir_q;
    if (state == ST_RESET) begin
      ir_en = 1'b1;
      ir_d  = OP_IDCODE;
    end else if (state == ST_IR_UPD) begin
      ir_en = 1'b1;
      ir_d  = sr_q;
    end
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)     sr_q <= IR_CAPTURE;
    else if (sr_en) sr_q <= sr_d;
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)     ir_q <= OP_IDCODE;
    else if (ir_en) ir_q <= ir_d;
  end

  assign ir     = ir_q;
  assign sr_lsb = sr_q[0];

endmodule

// File: rtl/scan_dr_regs.sv
module scan_dr_regs
  import scan_pkg::*;
#(
  parameter logic [DR_W-1:0] ID_VALUE   = '0,
  parameter logic [DR_W-1:0] USER_VALUE = '0
) (
  input  logic tck,
  input  logic rst_n,
  input  logic tdi,
  input  logic capture,
  input  logic shift,
  input  logic word_en,
  input  logic pick_user,
  output logic byp_bit,
  output logic word_lsb
);

  logic            byp_q;
  logic            byp_d;
  logic            byp_en;
  logic [DR_W-1:0] word_q;
  logic [DR_W-1:0] word_d;
  logic            wrd_en;

  always_comb begin
    byp_en = capture | shift;
    byp_d  = capture ? 1'b0 : tdi;
  end

  always_comb begin
    wrd_en = word_en & (capture | shift);
    if (capture) word_d = pick_user ? USER_VALUE : ID_VALUE;
    else         word_d = {tdi, word_q[DR_W-1:1]};
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)      byp_q <= 1'b0;
    else if (byp_en) byp_q <= byp_d;
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)      word_q <= ID_VALUE;
    else if (wrd_en) word_q <= word_d;
  end

  assign byp_bit  = byp_q;
  assign word_lsb = word_q[0];

endmodule

// File: rtl/scan_port_ctrl.sv
module scan_port_ctrl
  import scan_pkg::*;
#(
  parameter logic [VER_W-1:0] ID_VERSION = 4'h2,
  parameter logic [FAM_W-1:0] ID_FAMILY  = 7'h05,
  parameter logic [SIZ_W-1:0] ID_SIZE    = 9'h022,
  parameter logic [MFR_W-1:0] ID_MFR     = 11'h0A5,
  parameter logic [DR_W-1:0]  USER_WORD  = 32'hC0DE_5A17
) (
  input  logic tck,
  input  logic trst_n,
  input  logic tms,
  input  logic tdi,
  input  logic bsr_tdo,
  input  logic chain_a_tdo,
  input  logic chain_b_tdo,
  input  logic cfg_tdo,
  output logic tdo,
  output logic tdo_oe,
  output logic chain_tdi,
  output logic tlr_reset,
  output logic dr_capture,
  output logic dr_shift,
  output logic dr_update,
  output logic sel_extest,
  output logic sel_sample,
  output logic sel_intest,
  output logic sel_chain_a,
  output logic sel_chain_b,
  output logic sel_cfg_load,
  output logic sel_cfg_read,
  output logic sel_launch,
  output logic outputs_hiz,
  output logic start_run
);

  localparam logic [DR_W-1:0] ID_WORD = {ID_VERSION, ID_FAMILY, ID_SIZE, ID_MFR, 1'b1};

  // Reset: asserted asynchronously, released on TCK
  logic rst_meta_n;
  logic rst_sync_n;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  tap_state_e state;
  opcode_t    ir;
  decode_t    dec;
  logic       ir_lsb;
  logic       byp_bit;
  logic       word_lsb;
  logic       st_shift_ir;
  logic       tdo_d;
  logic       oe_d;
  logic       tdo_q;
  logic       oe_q;

  scan_tap_fsm u_fsm (
    .tck   (tck),
    .rst_n (rst_sync_n),
    .tms   (tms),
    .state (state)
  );

  scan_ir u_ir (
    .tck    (tck),
    .rst_n  (rst_sync_n),
    .tdi    (tdi),
    .state  (state),
    .ir     (ir),
    .sr_lsb (ir_lsb)
  );

  assign dec = decode_op(ir);

  assign tlr_reset   = (state == ST_RESET);
  assign dr_capture  = (state == ST_DR_CAP);
  assign dr_shift    = (state == ST_DR_SHIFT);
  assign dr_update   = (state == ST_DR_UPD);
  assign st_shift_ir = (state == ST_IR_SHIFT);

  scan_dr_regs #(
    .ID_VALUE   (ID_WORD),
    .USER_VALUE (USER_WORD)
  ) u_dr (
    .tck       (tck),
    .rst_n     (rst_sync_n),
    .tdi       (tdi),
    .capture   (dr_capture),
    .shift     (dr_shift),
    .word_en   (dec.src == SRC_WORD),
    .pick_user (dec.word_user),
    .byp_bit   (byp_bit),
    .word_lsb  (word_lsb)
  );

  always_comb begin
    oe_d  = st_shift_ir | dr_shift;
    tdo_d = 1'b0;
    if (st_shift_ir) begin
      tdo_d = ir_lsb;
    end else if (dr_shift) begin
      case (dec.src)
        SRC_WORD:     tdo_d = word_lsb;
        SRC_BOUNDARY: tdo_d = bsr_tdo;
        SRC_CHAIN_A:  tdo_d = chain_a_tdo;
        SRC_CHAIN_B:  tdo_d = chain_b_tdo;
        SRC_CFG:      tdo_d = cfg_tdo;
        default:      tdo_d = byp_bit;
      endcase
    end
  end

  // TDO stage on the falling edge of TCK
  always_ff @(negedge tck or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      tdo_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      tdo_q <= tdo_d;
      oe_q  <= oe_d;
    end
  end

  assign tdo          = tdo_q;
  assign tdo_oe       = oe_q;
  assign chain_tdi    = tdi;
  assign sel_extest   = dec.extest;
  assign sel_sample   = dec.sample;
  assign sel_intest   = dec.intest;
  assign sel_chain_a  = dec.chain_a;
  assign sel_chain_b  = dec.chain_b;
  assign sel_cfg_load = dec.cfg_load;
  assign sel_cfg_read = dec.cfg_read;
  assign sel_launch   = dec.launch;
  assign outputs_hiz  = dec.hiz;
  assign start_run    = dec.launch & (state == ST_IDLE);

endmodule

// File: rtl/scan_port_ctrl_chk.sv
module scan_port_ctrl_chk (
  input logic tck,
  input logic rst_n,
  input logic tms,
  input logic tdo_oe,
  input logic ir_shift,
  input logic tlr_reset,
  input logic dr_capture,
  input logic dr_shift,
  input logic start_run,
  input logic [8:0] sels
);

  logic [2:0] tms_run;

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)                tms_run <= '0;
    else if (!tms)             tms_run <= '0;
    else if (tms_run != 3'd7)  tms_run <= tms_run + 3'd1;
  end

  always @(posedge tck) begin
    if (rst_n === 1'b0) begin
      assert_reset_tlr_R1: assert (tlr_reset)
        else $error("R1: not in Test-Logic-Reset during reset");
    end
  end

  assert_tms_escape_R2: assert property (@(posedge tck) disable iff (!rst_n)
    (tms_run >= 3'd5) |-> tlr_reset)
    else $error("R2: five TMS highs did not reach Test-Logic-Reset");

  assert_sel_onehot_R7: assert property (@(posedge tck) disable iff (!rst_n)
    $onehot0(sels))
    else $error("R7: more than one instruction select high");

  assert_capture_shift_R12: assert property (@(posedge tck) disable iff (!rst_n)
    (dr_capture && !tms) |=> dr_shift)
    else $error("R12: Capture-DR with TMS low did not enter Shift-DR");

  assert_oe_window_R13: assert property (@(posedge tck) disable iff (!rst_n)
    tdo_oe == (dr_shift || ir_shift))
    else $error("R13: TDO enable outside a shift state");

  assert_launch_hold_R11: assert property (@(posedge tck) disable iff (!rst_n)
    (start_run && !tms) |=> start_run)
    else $error("R11: launch strobe dropped while idling");

endmodule

bind scan_port_ctrl scan_port_ctrl_chk u_chk (
  .tck        (tck),
  .rst_n      (rst_sync_n),
  .tms        (tms),
  .tdo_oe     (tdo_oe),
  .ir_shift   (st_shift_ir),
  .tlr_reset  (tlr_reset),
  .dr_capture (dr_capture),
  .dr_shift   (dr_shift),
  .start_run  (start_run),
  .sels       ({sel_extest, sel_sample, sel_intest, sel_chain_a, sel_chain_b,
                sel_cfg_load, sel_cfg_read, sel_launch, outputs_hiz})
);

// File: tb/scan_port_ctrl_test.sv
module scan_port_ctrl_test;

  localparam logic [31:0] EXP_ID = {4'h2, 7'h05, 9'h022, 11'h0A5, 1'b1};
  localparam logic [31:0] EXP_UC = 32'hC0DE_5A17;

  logic tck = 1'b0;
  always #5 tck = ~tck;

  logic trst_n, tms, tdi, bsr_tdo, chain_a_tdo, chain_b_tdo, cfg_tdo;
  logic tdo, tdo_oe, chain_tdi, tlr_reset, dr_capture, dr_shift, dr_update;
  logic sel_extest, sel_sample, sel_intest, sel_chain_a, sel_chain_b;
  logic sel_cfg_load, sel_cfg_read, sel_launch, outputs_hiz, start_run;

  scan_port_ctrl uut (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .bsr_tdo(bsr_tdo),
    .chain_a_tdo(chain_a_tdo), .chain_b_tdo(chain_b_tdo), .cfg_tdo(cfg_tdo),
    .tdo(tdo), .tdo_oe(tdo_oe), .chain_tdi(chain_tdi), .tlr_reset(tlr_reset),
    .dr_capture(dr_capture), .dr_shift(dr_shift), .dr_update(dr_update),
    .sel_extest(sel_extest), .sel_sample(sel_sample), .sel_intest(sel_intest),
    .sel_chain_a(sel_chain_a), .sel_chain_b(sel_chain_b),
    .sel_cfg_load(sel_cfg_load), .sel_cfg_read(sel_cfg_read),
    .sel_launch(sel_launch), .outputs_hiz(outputs_hiz), .start_run(start_run)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // scoreboard of expected TDO bits
  bit    exp_q[$];
  string tag_q[$];

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic push(input bit e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic tick(input logic m, input logic d);
    tms = m;
    tdi = d;
    @(posedge tck);
    @(negedge tck);
    #1;
  endtask

  // monitor: compares every driven TDO bit against the scoreboard
  always @(negedge tck) begin
    bit    e;
    string t;
    #2;
    if (tdo_oe === 1'b1) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R13 unexpected TDO bit act=%0b exp=none", tdo);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (tdo !== e) begin
          errors++;
          $display("FAIL %s tdo act=%0b exp=%0b", t, tdo, e);
        end
      end
    end
  end

  task automatic shift_ir(input logic [4:0] code);
    tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
    for (int i = 0; i < 5; i++) begin
      push(i == 0, "R3 capture pattern");
      tick(i == 4, code[i]);
    end
    tick(1, 0); tick(0, 0);
  endtask

  task automatic shift_dr(input int n, input logic [31:0] din,
                          input logic [31:0] exp, input string tag);
    tick(1, 0);
    tick(0, 0);
    chk(dr_capture, 1, "R12 capture strobe");
    tick(0, 0);
    chk(dr_shift, 1, "R12 shift strobe");
    for (int i = 0; i < n; i++) begin
      push(exp[i], tag);
      tick(i == n - 1, din[i]);
    end
    tick(1, 0);
    chk(dr_update, 1, "R12 update strobe");
    tick(0, 0);
    chk(tdo_oe, 0, "R13 enable low in idle");
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    checks++;
    errors++;
    $display("FAIL R12 watchdog act=running exp=done");
    finish_run();
  end

  initial begin
    logic v;
    trst_n = 1'b0; tms = 1'b1; tdi = 1'b0;
    bsr_tdo = 1'b0; chain_a_tdo = 1'b0; chain_b_tdo = 1'b0; cfg_tdo = 1'b0;
    tick(1, 0); tick(1, 0);
    chk(tlr_reset, 1, "R1 reset state");
    chk(tdo_oe, 0, "R13 enable low at reset");
    chk(start_run, 0, "R11 no launch at reset");
    trst_n = 1'b1;
    tick(0, 0);
    chk(tlr_reset, 1, "R1 held during release");
    tick(1, 0); tick(1, 0);
    tick(0, 0);
    chk(tlr_reset, 0, "R12 left reset");
    shift_dr(32, 32'h0, EXP_ID, "R1 R4 identification word");

    shift_ir(5'b11111);
    shift_dr(8, 32'hB3, {24'h0, 8'hB3 << 1}, "R5 bypass");
    shift_ir(5'b10110);
    shift_dr(6, 32'h2D, {26'h0, 6'h2D << 1}, "R5 reserved opcode");

    shift_ir(5'b01000);
    shift_dr(32, 32'h0, EXP_UC, "R6 user word");

    shift_ir(5'b00010);
    chk(sel_chain_a, 1, "R7 chain A select");
    chk(sel_chain_b, 0, "R7 chain B idle");
    chain_a_tdo = 1'b1;
    shift_dr(4, 32'h0, 32'hF, "R7 chain A return");
    chain_a_tdo = 1'b0;
    shift_ir(5'b00011);
    chk(sel_chain_b, 1, "R7 chain B select");
    chk(sel_chain_a, 0, "R7 chain A idle");
    chain_b_tdo = 1'b1;
    shift_dr(4, 32'h0, 32'hF, "R7 chain B return");
    chain_b_tdo = 1'b0;

    shift_ir(5'b00100);
    chk(sel_cfg_read, 1, "R8 readback select");
    cfg_tdo = 1'b1;
    shift_dr(3, 32'h0, 32'h7, "R8 readback return");
    shift_ir(5'b00101);
    chk(sel_cfg_load, 1, "R8 load select");
    chk(sel_cfg_read, 0, "R8 readback idle");
    shift_dr(8, 32'hFF, 32'hFF, "R8 load chain return");
    cfg_tdo = 1'b0;

    shift_ir(5'b01010);
    chk(outputs_hiz, 1, "R9 outputs float");
    shift_dr(4, 32'h6, 32'hC, "R9 bypass under HIGHZ");
    shift_ir(5'b01001);
    chk(outputs_hiz, 0, "R9 float released");

    bsr_tdo = 1'b1;
    shift_ir(5'b00000);
    chk(sel_extest, 1, "R10 extest select");
    shift_dr(3, 32'h0, 32'h7, "R10 boundary return");
    shift_ir(5'b00001);
    chk(sel_sample, 1, "R10 sample select");
    shift_ir(5'b00111);
    chk(sel_intest, 1, "R10 intest select");
    chk(sel_extest, 0, "R10 extest idle");
    bsr_tdo = 1'b0;

    shift_ir(5'b01100);
    chk(sel_launch, 1, "R11 launch select");
    shift_dr(1, 32'h0, 32'h0, "R11 launch bypass");
    chk(start_run, 1, "R11 launch in idle");
    tick(0, 0);
    chk(start_run, 1, "R11 launch held");
    tick(1, 0);
    chk(start_run, 0, "R11 launch off outside idle");
    tick(1, 0); tick(0, 0); tick(1, 0); tick(0, 0);
    for (int i = 0; i < 5; i++) tick(1, 0);
    chk(tlr_reset, 1, "R2 escape from Pause-IR");
    chk(sel_launch, 0, "R2 instruction back to IDCODE");
    tick(0, 0);
    shift_dr(32, 32'h0, EXP_ID, "R2 identification after escape");

    tick(1, 0); tick(0, 0); tick(0, 0);
    push(EXP_ID[0], "R4 first bit");
    for (int i = 0; i < 5; i++) tick(1, 0);
    chk(tlr_reset, 1, "R2 escape from Shift-DR");
    tick(0, 0);

    shift_ir(5'b01000);
    tick(1, 0); tick(0, 0);
    tms = 1'b0; tdi = 1'b0;
    @(posedge tck); #1;
    chk(tdo_oe, 0, "R13 enable waits for falling edge");
    @(negedge tck); #1;
    chk(tdo_oe, 1, "R13 enable on falling edge");
    push(EXP_UC[0], "R6 user bit 0");
    v = tdo;
    @(posedge tck); #1;
    chk(tdo, v, "R13 TDO stable over rising edge");
    @(negedge tck); #1;
    push(EXP_UC[1], "R6 user bit 1");
    chk(tdo, EXP_UC[1], "R13 TDO moves on falling edge");
    tick(1, 0); tick(1, 0); tick(0, 0);

    tick(0, 0); tick(0, 0);
    chk(exp_q.size(), 0, "R13 all expected bits seen");
    finish_run();
  end

endmodule